// File: doc/BRIEF.md
# Character-Clock CRT Timing Generator

This block produces the raster timing for a cathode-ray or flat display: horizontal sync, vertical sync, a combined blanking signal, a display-enable signal and a linear video memory address. One clock cycle is one character clock, which stands for eight pixels. Horizontal parameters are counted in characters and vertical parameters in scan lines. The timing registers use compact, biased encodings: totals carry a fixed offset, the end of a blank or sync window is compared only against the low bits of the running counter, and the upper vertical bits are gathered in a shared overflow register.

Software programs the block through a two-step port. A write with `reg_sel` low loads an index, and a write with `reg_sel` high stores a byte into the indexed register. A protect bit freezes the eight low-indexed registers so that later writes cannot disturb the horizontal timing. The memory address counter restarts at a programmable start address at the top of each frame and steps by twice the row offset per displayed row. A double-scan mode shows each row on two scan lines.

Top module: `crt_timing_gen`

## Requirements
- R1: Each line lasts HTOT+5 character clocks, where HTOT is register 0, and each frame lasts VT+2 lines. VT is 10 bits: bits 7:0 are register 6, bit 8 is register 7 bit 0 and bit 9 is register 7 bit 5. The character counter wraps to 0 when it is at or above its last value, and the line counter then advances or wraps.
- R2: `disp_en` is high exactly when the character count is at most register 1 and the line count is at most VDE. VDE is 10 bits: bits 7:0 are register 13, bit 8 is register 7 bit 1 and bit 9 is register 7 bit 6.
- R3: The horizontal sync window opens at the character whose count equals register 4. It stays open until the first later character whose count, in its low 5 bits, equals register 5 bits 4:0, and it is closed at that character.
- R4: The horizontal blank window opens at register 2 and closes on a 6-bit match. The end value takes bits 4:0 from register 3 and bit 5 from register 5 bit 7. `blank` is the OR of the horizontal and vertical blank windows.
- R5: The vertical sync window opens at VSS and closes on a match against the low 4 bits of the line count, with the end value in register 12 bits 3:0. VSS is {reg7[7], reg7[2], reg11}. The vertical blank window opens at VBS and closes on an 8-bit match against register 16. VBS is {reg8[5], reg7[3], reg15}.
- R6: Register 17 bit 0 set makes `hsync` active-low, and bit 1 set makes `vsync` active-low. When a bit is clear, the matching sync output is active-high.
- R7: `mem_addr` equals the row base plus the character count, modulo 2^16. The row base loads {reg9, reg10} at the top of a frame and grows by 2 times register 14 after each displayed row.
- R8: With register 8 bit 7 set, the row base advances only after odd lines, so each row is shown on two scan lines.
- R9: Register 12 bit 7 set blocks data writes to registers 0 to 7. Writes to registers 8 to 17 still take effect, and so do writes to the protect register itself.
- R10: While `rst_n` is low, every register, the index, both counters and the row base are zero, so `mem_addr` is 0. Counting and register writes start on the third rising clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0: write index, 1: write data to indexed register |
| reg_wdata | input | 8 | Index or data byte |
| hsync | output | 1 | Horizontal sync, polarity per R6 |
| vsync | output | 1 | Vertical sync, polarity per R6 |
| blank | output | 1 | Horizontal or vertical blanking |
| disp_en | output | 1 | Visible area |
| mem_addr | output | 16 | Video memory character address |

## Verification
The assertions check the following on every cycle:
- Each window latch opens on its start match and closes on its end match.
- The line counter holds between line ends, and both counters return to zero after a frame end.
- The row base reloads at the frame top and steps by the offset, or holds on even lines under double scan.
- The protected registers stay unchanged under a blocked write.

Only the bench's scenarios can show that the whole window shapes, the biased totals, the split overflow bits, sync polarity and address wrap-around reach the outputs correctly. The bench covers these with several full-frame sweeps, including the protect case.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int REG_W      = 8;
  localparam int IDX_W      = 5;
  localparam int NREG       = 18;
  localparam int PROT_LIMIT = 8;
  localparam int HCNT_W     = 9;
  localparam int VCNT_W     = 10;
  localparam int ADDR_W     = 16;
  localparam int HBE_W      = 6;
  localparam int HSE_W      = 5;
  localparam int VSE_W      = 4;
  localparam int VBE_W      = 8;
  localparam int H_BIAS     = 5;
  localparam int V_BIAS     = 2;

  localparam int IX_HTOT = 0;
  localparam int IX_HDE  = 1;
  localparam int IX_HBS  = 2;
  localparam int IX_HBE  = 3;
  localparam int IX_HSS  = 4;
  localparam int IX_HSE  = 5;
  localparam int IX_VTOT = 6;
  localparam int IX_OVF  = 7;
  localparam int IX_MSL  = 8;
  localparam int IX_SAH  = 9;
  localparam int IX_SAL  = 10;
  localparam int IX_VSS  = 11;
  localparam int IX_VSE  = 12;
  localparam int IX_VDE  = 13;
  localparam int IX_OFS  = 14;
  localparam int IX_VBS  = 15;
  localparam int IX_VBE  = 16;
  localparam int IX_POL  = 17;

  typedef struct packed {
    logic [REG_W-1:0]  htot;
    logic [REG_W-1:0]  hde;
    logic [REG_W-1:0]  hbs;
    logic [REG_W-1:0]  hss;
    logic [HBE_W-1:0]  hbe;
    logic [HSE_W-1:0]  hse;
    logic [VCNT_W-1:0] vtot;
    logic [VCNT_W-1:0] vde;
    logic [VCNT_W-1:0] vbs;
    logic [VCNT_W-1:0] vss;
    logic [VBE_W-1:0]  vbe;
    logic [VSE_W-1:0]  vse;
    logic              dbl;
    logic [ADDR_W-1:0] start;
    logic [REG_W-1:0]  ofs;
    logic              hpol;
    logic              vpol;
  } crt_cfg_t;
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile
  import crt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output crt_cfg_t         cfg
);
  localparam logic [IDX_W-1:0] NREG_IX = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] PROT_IX = IDX_W'(PROT_LIMIT);

  logic [REG_W-1:0] regs_q [NREG];
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             prot, idx_we, data_we;
  logic [REG_W*PROT_LIMIT-1:0] prot_view;
  logic             unused_regbits;

  assign prot    = regs_q[IX_VSE][7];
  assign idx_we  = reg_wr & ~reg_sel;
  assign data_we = reg_wr & reg_sel & (idx_q < NREG_IX) & ~(prot & (idx_q < PROT_IX));

  always_comb begin
    idx_d = idx_q;
    if (idx_we) idx_d = reg_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      idx_q <= idx_d;
      if (data_we) regs_q[idx_q] <= reg_wdata;
    end
  end

  for (genvar g = 0; g < PROT_LIMIT; g++) begin : g_prot_view
    assign prot_view[g*REG_W +: REG_W] = regs_q[g];
  end

  always_comb begin
    cfg       = '0;
    cfg.htot  = regs_q[IX_HTOT];
    cfg.hde   = regs_q[IX_HDE];
    cfg.hbs   = regs_q[IX_HBS];
    cfg.hss   = regs_q[IX_HSS];
    cfg.hbe   = {regs_q[IX_HSE][7], regs_q[IX_HBE][HSE_W-1:0]};
    cfg.hse   = regs_q[IX_HSE][HSE_W-1:0];
    cfg.vtot  = {regs_q[IX_OVF][5], regs_q[IX_OVF][0], regs_q[IX_VTOT]};
    cfg.vde   = {regs_q[IX_OVF][6], regs_q[IX_OVF][1], regs_q[IX_VDE]};
    cfg.vss   = {regs_q[IX_OVF][7], regs_q[IX_OVF][2], regs_q[IX_VSS]};
    cfg.vbs   = {regs_q[IX_MSL][5], regs_q[IX_OVF][3], regs_q[IX_VBS]};
    cfg.vbe   = regs_q[IX_VBE];
    cfg.vse   = regs_q[IX_VSE][VSE_W-1:0];
    cfg.dbl   = regs_q[IX_MSL][7];
    cfg.start = {regs_q[IX_SAH], regs_q[IX_SAL]};
    cfg.ofs   = regs_q[IX_OFS];
    cfg.hpol  = regs_q[IX_POL][0];
    cfg.vpol  = regs_q[IX_POL][1];
  end

  assign unused_regbits = ^{regs_q[IX_MSL][6], regs_q[IX_MSL][4:0],
                            regs_q[IX_VSE][6:4], regs_q[IX_POL][7:2]};

  AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && prot && (idx_q < PROT_IX)) |=> $stable(prot_view)); // R9
endmodule

// File: rtl/crt_counters.sv
module crt_counters
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  htot,
  input  logic [VCNT_W-1:0] vtot,
  output logic [HCNT_W-1:0] hcnt,
  output logic [VCNT_W-1:0] vcnt,
  output logic              line_end,
  output logic              frame_end
);
  logic [HCNT_W-1:0] hcnt_q, hcnt_d, h_last;
  logic [VCNT_W-1:0] vcnt_q, vcnt_d;
  logic [VCNT_W:0]   v_last;

  assign h_last    = HCNT_W'(htot) + HCNT_W'(H_BIAS - 1);
  assign v_last    = {1'b0, vtot} + (VCNT_W+1)'(V_BIAS - 1);
  assign line_end  = (hcnt_q >= h_last);
  assign frame_end = line_end & ({1'b0, vcnt_q} >= v_last);

  always_comb begin
    hcnt_d = hcnt_q + 1'b1;
    vcnt_d = vcnt_q;
    if (line_end) begin
      hcnt_d = '0;
      vcnt_d = frame_end ? '0 : vcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
    end
  end

  assign hcnt = hcnt_q;
  assign vcnt = vcnt_q;

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcnt_q)); // R1
  AST_FRAME_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (hcnt_q == '0) && (vcnt_q == '0)); // R1
endmodule

// File: rtl/crt_window.sv
module crt_window #(
  parameter int CNT_W = 9,
  parameter int END_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] start,
  input  logic [END_W-1:0] end_val,
  output logic             active
);
  logic act_q, act_d, start_hit, end_hit;

  assign start_hit = (pos == start);
  assign end_hit   = (pos[END_W-1:0] == end_val);
  assign active    = start_hit | (act_q & ~end_hit);

  always_comb begin
    act_d = act_q;
    if (adv) act_d = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && start_hit) |=> act_q); // R3
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && act_q && end_hit && !start_hit) |=> !act_q); // R3
endmodule

// File: rtl/crt_addr_gen.sv
module crt_addr_gen
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              frame_end,
  input  logic              dbl,
  input  logic [ADDR_W-1:0] start,
  input  logic [REG_W-1:0]  ofs,
  input  logic [HCNT_W-1:0] hcnt,
  output logic [ADDR_W-1:0] mem_addr
);
  logic [ADDR_W-1:0] row_q, row_d, step;
  logic              par_q, par_d, row_ce;

  assign step   = ADDR_W'({ofs, 1'b0});
  assign row_ce = line_end & (~dbl | par_q);

  always_comb begin
    row_d = row_q;
    par_d = par_q;
    if (line_end) begin
      if (frame_end) begin
        row_d = start;
        par_d = 1'b0;
      end else begin
        par_d = ~par_q;
        if (row_ce) row_d = row_q + step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      par_q <= 1'b0;
    end else begin
      row_q <= row_d;
      par_q <= par_d;
    end
  end

  assign mem_addr = row_q + ADDR_W'(hcnt);

  AST_ADDR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && frame_end) |=> (row_q == $past(start))); // R7
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end && (!dbl || par_q)) |=> (row_q == $past(row_q) + $past(step))); // R7
  AST_DBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end && dbl && !par_q) |=> $stable(row_q)); // R8
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              disp_en,
  output logic [15:0]       mem_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  crt_cfg_t          cfg;
  logic [HCNT_W-1:0] hcnt;
  logic [VCNT_W-1:0] vcnt;
  logic              line_end, frame_end;
  logic              hs_act, hb_act, vs_act, vb_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  crt_regfile u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cfg(cfg)
  );

  crt_counters u_cnt (
    .clk(clk), .rst_n(rst_int_n), .htot(cfg.htot), .vtot(cfg.vtot),
    .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end), .frame_end(frame_end)
  );

  crt_window #(.CNT_W(HCNT_W), .END_W(HSE_W)) u_hsync_win (
    .clk(clk), .rst_n(rst_int_n), .adv(1'b1), .pos(hcnt),
    .start(HCNT_W'(cfg.hss)), .end_val(cfg.hse), .active(hs_act)
  );

  crt_window #(.CNT_W(HCNT_W), .END_W(HBE_W)) u_hblank_win (
    .clk(clk), .rst_n(rst_int_n), .adv(1'b1), .pos(hcnt),
    .start(HCNT_W'(cfg.hbs)), .end_val(cfg.hbe), .active(hb_act)
  );

  crt_window #(.CNT_W(VCNT_W), .END_W(VSE_W)) u_vsync_win (
    .clk(clk), .rst_n(rst_int_n), .adv(line_end), .pos(vcnt),
    .start(cfg.vss), .end_val(cfg.vse), .active(vs_act)
  );

  crt_window #(.CNT_W(VCNT_W), .END_W(VBE_W)) u_vblank_win (
    .clk(clk), .rst_n(rst_int_n), .adv(line_end), .pos(vcnt),
    .start(cfg.vbs), .end_val(cfg.vbe), .active(vb_act)
  );

  crt_addr_gen u_addr (
    .clk(clk), .rst_n(rst_int_n), .line_end(line_end), .frame_end(frame_end),
    .dbl(cfg.dbl), .start(cfg.start), .ofs(cfg.ofs), .hcnt(hcnt),
    .mem_addr(mem_addr)
  );

  assign hsync   = hs_act ^ cfg.hpol;
  assign vsync   = vs_act ^ cfg.vpol;
  assign blank   = hb_act | vb_act;
  assign disp_en = (hcnt <= HCNT_W'(cfg.hde)) & (vcnt <= cfg.vde);
endmodule

// File: tb/crt_timing_gen_tb_top.sv
module crt_timing_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, reg_wr, reg_sel;
  logic [7:0]  reg_wdata;
  logic        hsync, vsync, blank, disp_en;
  logic [15:0] mem_addr;

  crt_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .hsync(hsync), .vsync(vsync), .blank(blank),
    .disp_en(disp_en), .mem_addr(mem_addr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench-side model of the register file and raster position (R1, R9, R10)
  logic [1:0] m_sync;
  logic [7:0] sh [18];
  logic [4:0] m_idx;
  int hpos, vpos, tops;

  function automatic int vtot_f();  return int'({sh[7][5], sh[7][0], sh[6]});  endfunction
  function automatic int vde_f();   return int'({sh[7][6], sh[7][1], sh[13]}); endfunction
  function automatic int vss_f();   return int'({sh[7][7], sh[7][2], sh[11]}); endfunction
  function automatic int vbs_f();   return int'({sh[8][5], sh[7][3], sh[15]}); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00;
      m_idx  <= '0;
      hpos   <= 0;
      vpos   <= 0;
      tops   <= 0;
      for (int i = 0; i < 18; i++) sh[i] <= 8'h00;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        if (reg_wr && !reg_sel) m_idx <= reg_wdata[4:0];
        if (reg_wr && reg_sel && m_idx < 5'd18 && !(sh[12][7] && m_idx < 5'd8))
          sh[m_idx] <= reg_wdata;
        if (hpos >= int'(sh[0]) + 4) begin
          hpos <= 0;
          if (vpos >= vtot_f() + 1) begin
            vpos <= 0;
            tops <= tops + 1;
          end else vpos <= vpos + 1;
        end else hpos <= hpos + 1;
      end
    end
  end

  function automatic bit in_win(int p, int s, int e, int m);
    int l;
    l = ((e - s) % m + m) % m;
    if (l == 0) l = m;
    return (p >= s) && (p < s + l);
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d (h=%0d v=%0d)", what, got, exp, hpos, vpos);
    end
  endtask

  task automatic check_cycle(input string tag);
    int e_hs, e_vs, e_bl, e_de, e_ad, row;
    e_hs = int'(in_win(hpos, int'(sh[4]), int'(sh[5][4:0]), 32)) ^ int'(sh[17][0]);
    e_vs = int'(in_win(vpos, vss_f(), int'(sh[12][3:0]), 16)) ^ int'(sh[17][1]);
    e_bl = int'(in_win(hpos, int'(sh[2]), int'({sh[5][7], sh[3][4:0]}), 64) ||
                in_win(vpos, vbs_f(), int'(sh[16]), 256));
    e_de = int'((hpos <= int'(sh[1])) && (vpos <= vde_f()));
    row  = sh[8][7] ? vpos / 2 : vpos;
    e_ad = (int'({sh[9], sh[10]}) + row * 2 * int'(sh[14]) + hpos) % 65536;
    chk({"R3/R6 hsync ", tag}, int'(hsync), e_hs);
    chk({"R5/R6 vsync ", tag}, int'(vsync), e_vs);
    chk({"R4/R5 blank ", tag}, int'(blank), e_bl);
    chk({"R1/R2 disp_en ", tag}, int'(disp_en), e_de);
    chk({"R1/R7/R8 mem_addr ", tag}, int'(mem_addr), e_ad);
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'(idx);
    @(negedge clk);
    reg_sel = 1'b1; reg_wdata = 8'(val);
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic load_cfg(input int v [18]);
    for (int i = 0; i < 18; i++) wr(i, v[i]);
  endtask

  task automatic run_frames(input int n, input string tag);
    int target;
    @(negedge clk);
    target = tops + 2;
    while (tops < target) @(negedge clk);
    target = tops + n;
    while (tops < target) begin
      check_cycle(tag);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 mem_addr in reset", int'(mem_addr), 0);
    check_cycle("R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Small frame, all windows inside the line (R1 R2 R3 R4 R5 R7)
    load_cfg('{15, 11, 12, 19, 14, 17, 10, 0, 0, 8'h01, 8'h00, 9, 10, 7, 6, 8, 11, 0});
    run_frames(2, "cfgA R1");

    // 6-bit blank end with bit 5, double scan, both polarities low, address wrap (R4 R6 R8)
    load_cfg('{35, 31, 32, 7, 33, 8'h85, 2, 8'h01, 8'h80, 8'hFF, 8'hF0, 252, 0, 239, 3, 250, 2, 3});
    run_frames(2, "cfgB R4/R8");

    // Vertical fields using bits 8 and 9 of the split encodings (R1 R2 R5)
    load_cfg('{3, 5, 6, 7, 6, 7, 2, 8'h26, 8'h20, 8'h12, 8'h34, 8'h2C, 1, 8'hFF, 8'h40, 8'h00, 3, 1});
    run_frames(2, "cfgC R5");

    // R9: protect blocks registers 0..7, unprotected register still writable
    wr(12, 8'h81);
    wr(0, 9);
    wr(4, 0);
    wr(7, 0);
    wr(17, 2);
    run_frames(2, "protect R9");
    wr(12, 8'h01);
    wr(0, 5);
    run_frames(1, "unprotect R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule